// File: doc/BRIEF.md
# Transceiver Control Register Bank with Set and Clear Write Aliases

This block holds the 8-bit control state of a USB transceiver and exposes it to a host over a simple synchronous register bus. The bus has a single address, a write strobe with write data, and a read strobe. Read data appears one clock after the read strobe. The register contents drive the transceiver's control pins directly: speed selection, operating mode, termination, reset, suspend, interface and OTG controls, debounce and timer settings, PHY power and PHY clock control.

Three of the registers take writes at three consecutive addresses. A write to the base address loads the whole register. A write to base+1 sets the bits that are 1 in the data. A write to base+2 clears the bits that are 1 in the data. With the set and clear addresses, software can change individual bits without first reading the register. Five more registers are direct-only: any write to them replaces the whole value. One status location reports whether the PLL clock is present.

The aliased registers are function control (base 0x04), interface control (base 0x07) and OTG control (base 0x0A). The direct-only registers are at 0xC0 (VBUS debounce), 0xC1 (ID debounce), 0xD3 (battery timer), 0xFD (PHY power) and 0xFE (PHY clock control). The status location is 0xFF.

Top module: `xcvr_regbank`

## Requirements
- R1: A synchronous reset sets every register to 0x00, except the PHY power register at 0xFD, which resets to 0x01 (bit 0 is power-down). Reset also clears rd_data to 0x00.
- R2: A write to base address 0x04, 0x07 or 0x0A replaces the whole register. The new value is visible at the outputs after the next clock edge.
- R3: A write to base+1 (0x05, 0x08 or 0x0B) ORs the write data into the register. Bits whose data bit is 0 keep their value.
- R4: A write to base+2 (0x06, 0x09 or 0x0C) clears each register bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R5: The function-control register drives these fields:
  - suspend_n from bit 6
  - xcvr_reset from bit 5
  - op_mode from bits 4:3, where 0 is normal, 1 is non-driving and 2 is bit-stuff/NRZI disabled
  - term_sel from bit 2
  - speed_sel from bits 1:0, where 0 is high speed, 1 is full speed, 2 is low speed and 3 is full speed carrying low-speed traffic
- R6: The registers at 0xC0, 0xC1, 0xD3, 0xFD and 0xFE are direct-only. A write to any of them replaces its whole value, including writes to 0xC1, which follows 0xC0 directly.
- R7: Address 0xFF is read-only. A read returns pll_clk_ok in bit 0 and 0 in bits 7:1. Writes to 0xFF change nothing.
- R8: A read of a set alias or a clear alias returns the current value of its base register.
- R9: A write to an unmapped address changes no register. A read of an unmapped address returns 0x00.
- R10: rd_data takes the selected value one clock after rd_en. If a write to the same address happens in that same cycle, rd_data shows the value from before the write. While rd_en is low, rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pll_clk_ok | input | 1 | PLL clock present, reported at 0xFF bit 0 |
| suspend_n | output | 1 | Function control bit 6 |
| xcvr_reset | output | 1 | Function control bit 5 |
| op_mode | output | 2 | Function control bits 4:3 |
| term_sel | output | 1 | Function control bit 2 |
| speed_sel | output | 2 | Function control bits 1:0 |
| ifc_ctrl | output | 8 | Interface control register |
| otg_ctrl | output | 8 | OTG control register |
| vbus_dbnc | output | 8 | VBUS debounce setting |
| id_dbnc | output | 8 | ID debounce setting |
| batt_timer | output | 8 | Battery timer setting |
| phy_pwr | output | 8 | PHY power register (bit 0 is power-down) |
| clk_ctrl | output | 8 | PHY clock control register |

## Verification
The bench uses the default configuration: 8-bit data, 8-bit addresses, three aliased registers and five direct-only registers.

With an 8-bit address, the bench can read all 256 addresses and write to every unmapped address. It therefore compares the whole map against its own model, not only sample addresses.

With 8-bit data, it also drives all 256 values through function control and checks each field decode. Set and clear are checked on every aliased register, using patterns computed in the bench.

// File: rtl/xcvr_regbank_pkg.sv
package xcvr_regbank_pkg;

    localparam int DW       = 8;
    localparam int AW       = 8;
    localparam int N_ALIAS  = 3;
    localparam int N_DIRECT = 5;
    localparam int N_REGS   = N_ALIAS + N_DIRECT;
    localparam int IDXW     = $clog2(N_REGS);

    localparam logic [AW-1:0] STATUS_ADDR = AW'(8'hFF);
    localparam int            PWR_IDX     = 6;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } reg_op_e;

    typedef struct packed {
        logic            hit;
        logic [IDXW-1:0] idx;
        reg_op_e         op;
    } reg_dec_t;

    // Base addresses of the registers that carry set and clear aliases.
    function automatic logic [AW-1:0] alias_base(input int i);
        case (i)
            0:       return AW'(8'h04);
            1:       return AW'(8'h07);
            default: return AW'(8'h0A);
        endcase
    endfunction

    // Addresses of the registers that take plain writes only.
    function automatic logic [AW-1:0] direct_addr(input int i);
        case (i)
            0:       return AW'(8'hC0);
            1:       return AW'(8'hC1);
            2:       return AW'(8'hD3);
            3:       return AW'(8'hFD);
            default: return AW'(8'hFE);
        endcase
    endfunction

    function automatic logic [DW-1:0] reset_val(input int i);
        return (i == PWR_IDX) ? DW'(1) : '0;
    endfunction

    function automatic reg_dec_t decode(input logic [AW-1:0] a);
        reg_dec_t d;
        d = '{hit: 1'b0, idx: '0, op: OP_NONE};
        for (int i = 0; i < N_ALIAS; i++) begin
            if (a == alias_base(i)) begin
                d = '{hit: 1'b1, idx: IDXW'(i), op: OP_LOAD};
            end else if (a == alias_base(i) + AW'(1)) begin
                d = '{hit: 1'b1, idx: IDXW'(i), op: OP_SET};
            end else if (a == alias_base(i) + AW'(2)) begin
                d = '{hit: 1'b1, idx: IDXW'(i), op: OP_CLEAR};
            end
        end
        for (int j = 0; j < N_DIRECT; j++) begin
            if (a == direct_addr(j)) begin
                d = '{hit: 1'b1, idx: IDXW'(N_ALIAS + j), op: OP_LOAD};
            end
        end
        return d;
    endfunction

    function automatic logic [DW-1:0] apply_op(input reg_op_e op,
                                               input logic [DW-1:0] cur,
                                               input logic [DW-1:0] d);
        case (op)
            OP_LOAD:  return d;
            OP_SET:   return cur | d;
            OP_CLEAR: return cur & ~d;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/xcvr_regbank_decode.sv
module xcvr_regbank_decode
    import xcvr_regbank_pkg::*;
(
    input  logic [AW-1:0] addr,
    output reg_dec_t      dec,
    output logic          is_status
);
    always_comb begin
        dec       = decode(addr);
        is_status = (addr == STATUS_ADDR);
    end
endmodule

// File: rtl/xcvr_regbank_cell.sv
module xcvr_regbank_cell
    import xcvr_regbank_pkg::*;
#(
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  reg_op_e       op,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (op != OP_NONE) begin
            q <= apply_op(op, q, din);
        end
    end
endmodule

// File: rtl/xcvr_regbank.sv
module xcvr_regbank
    import xcvr_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          pll_clk_ok,
    output logic          suspend_n,
    output logic          xcvr_reset,
    output logic [1:0]    op_mode,
    output logic          term_sel,
    output logic [1:0]    speed_sel,
    output logic [DW-1:0] ifc_ctrl,
    output logic [DW-1:0] otg_ctrl,
    output logic [DW-1:0] vbus_dbnc,
    output logic [DW-1:0] id_dbnc,
    output logic [DW-1:0] batt_timer,
    output logic [DW-1:0] phy_pwr,
    output logic [DW-1:0] clk_ctrl
);
    reg_dec_t      dec;
    logic          is_status;
    logic [DW-1:0] regs [N_REGS];
    logic [DW-1:0] rd_next;

    xcvr_regbank_decode u_dec (
        .addr      (addr),
        .dec       (dec),
        .is_status (is_status)
    );

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        reg_op_e cell_op;
        always_comb begin
            cell_op = OP_NONE;
            if (wr_en && dec.hit && dec.idx == IDXW'(g)) cell_op = dec.op;
        end
        xcvr_regbank_cell #(.RST_VAL(reset_val(g))) u_cell (
            .clk (clk),
            .rst (rst),
            .op  (cell_op),
            .din (wr_data),
            .q   (regs[g])
        );
    end

    always_comb begin
        if (is_status)    rd_next = DW'(pll_clk_ok);
        else if (dec.hit) rd_next = regs[dec.idx];
        else              rd_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    assign suspend_n  = regs[0][6];
    assign xcvr_reset = regs[0][5];
    assign op_mode    = regs[0][4:3];
    assign term_sel   = regs[0][2];
    assign speed_sel  = regs[0][1:0];
    assign ifc_ctrl   = regs[1];
    assign otg_ctrl   = regs[2];
    assign vbus_dbnc  = regs[3];
    assign id_dbnc    = regs[4];
    assign batt_timer = regs[5];
    assign phy_pwr    = regs[6];
    assign clk_ctrl   = regs[7];
endmodule

// File: rtl/xcvr_regbank_chk.sv
module xcvr_regbank_chk
    import xcvr_regbank_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          pll_clk_ok,
    input logic [DW-1:0] ifc_ctrl,
    input logic [DW-1:0] phy_pwr
);
    AST_IFC_SET_ORS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(8'h08)) |=> ifc_ctrl == ($past(ifc_ctrl) | $past(wr_data))); // R3

    AST_IFC_CLR_MASKS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(8'h09)) |=> ifc_ctrl == ($past(ifc_ctrl) & ~$past(wr_data))); // R4

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == STATUS_ADDR) |=> rd_data == DW'($past(pll_clk_ok))); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == AW'(8'h50)) |=> rd_data == '0); // R9

    AST_RD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R10

    AST_PWR_ONLY_OWN_ADDR: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == AW'(8'hFD)) |=> $stable(phy_pwr)); // R6
endmodule

bind xcvr_regbank xcvr_regbank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .pll_clk_ok (pll_clk_ok),
    .ifc_ctrl   (ifc_ctrl),
    .phy_pwr    (phy_pwr)
);

// File: tb/xcvr_regbank_tb.sv
module xcvr_regbank_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       pll_clk_ok = 1'b0;
    logic       suspend_n, xcvr_reset, term_sel;
    logic [1:0] op_mode, speed_sel;
    logic [7:0] ifc_ctrl, otg_ctrl, vbus_dbnc, id_dbnc, batt_timer, phy_pwr, clk_ctrl;

    int errors = 0;
    int checks = 0;
    logic [7:0] m [8];

    always #10 clk = ~clk;

    xcvr_regbank u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pll_clk_ok(pll_clk_ok),
        .suspend_n(suspend_n), .xcvr_reset(xcvr_reset), .op_mode(op_mode),
        .term_sel(term_sel), .speed_sel(speed_sel), .ifc_ctrl(ifc_ctrl),
        .otg_ctrl(otg_ctrl), .vbus_dbnc(vbus_dbnc), .id_dbnc(id_dbnc),
        .batt_timer(batt_timer), .phy_pwr(phy_pwr), .clk_ctrl(clk_ctrl)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Bench address map: returns model index, or -1; op 1 load, 2 set, 3 clear.
    function automatic int map_idx(input logic [7:0] a, output int op);
        logic [7:0] bases [3] = '{8'h04, 8'h07, 8'h0A};
        logic [7:0] dirs  [5] = '{8'hC0, 8'hC1, 8'hD3, 8'hFD, 8'hFE};
        op = 0;
        for (int i = 0; i < 3; i++)
            if (a >= bases[i] && a <= bases[i] + 8'd2) begin
                op = 1 + int'(a - bases[i]);
                return i;
            end
        for (int j = 0; j < 5; j++)
            if (a == dirs[j]) begin
                op = 1;
                return 3 + j;
            end
        return -1;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        int op;
        int k;
        if (a == 8'hFF) return {7'b0, pll_clk_ok};
        k = map_idx(a, op);
        return (k < 0) ? 8'h00 : m[k];
    endfunction

    task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
        int op;
        int k;
        k = map_idx(a, op);
        if (k >= 0) begin
            if (op == 1)      m[k] = d;
            else if (op == 2) m[k] = m[k] | d;
            else              m[k] = m[k] & ~d;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        logic [7:0] e;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        e = exp_rd(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, e);
    endtask

    task automatic chk_outputs(input string req);
        check(req, {1'b0, suspend_n, xcvr_reset, op_mode, term_sel, speed_sel}, m[0] & 8'h7F);
        check(req, ifc_ctrl, m[1]);
        check(req, otg_ctrl, m[2]);
        check(req, vbus_dbnc, m[3]);
        check(req, id_dbnc, m[4]);
        check(req, batt_timer, m[5]);
        check(req, phy_pwr, m[6]);
        check(req, clk_ctrl, m[7]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] held;
        for (int k = 0; k < 8; k++) m[k] = (k == 6) ? 8'h01 : 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset defaults
        check("R1 rd_data", rd_data, 8'h00);
        chk_outputs("R1");

        // R2 R3 R4 R8: load, set, clear on each aliased register
        for (int r = 0; r < 3; r++) begin
            logic [7:0] base;
            base = (r == 0) ? 8'h04 : (r == 1) ? 8'h07 : 8'h0A;
            for (int p = 0; p < 6; p++) begin
                logic [7:0] v;
                v = 8'(p * 53 + r * 29 + 7);
                wr(base, v);
                chk_outputs("R2");
                wr(base + 8'd1, 8'(v * 3 + 8'h11));
                chk_outputs("R3");
                wr(base + 8'd2, 8'(v ^ 8'h5A));
                chk_outputs("R4");
                rd_chk("R8 base", base);
                rd_chk("R8 set alias", base + 8'd1);
                rd_chk("R8 clear alias", base + 8'd2);
            end
        end

        // R5: every function-control value decoded into fields
        for (int v = 0; v < 256; v++) begin
            wr(8'h04, 8'(v));
            check("R5 fields", {1'b0, suspend_n, xcvr_reset, op_mode, term_sel, speed_sel},
                  8'(v) & 8'h7F);
        end

        // R6: direct-only registers take whole-value writes
        wr(8'hC0, 8'hF0);
        wr(8'hC1, 8'h0F);
        wr(8'hC1, 8'h30);
        wr(8'hD3, 8'hA5);
        wr(8'hFD, 8'h00);
        wr(8'hFE, 8'h07);
        wr(8'hFE, 8'h02);
        chk_outputs("R6");
        check("R6 id_dbnc plain", id_dbnc, 8'h30);
        check("R6 clk_ctrl plain", clk_ctrl, 8'h02);

        // R7: status location
        pll_clk_ok = 1'b1;
        rd_chk("R7 pll high", 8'hFF);
        wr(8'hFF, 8'hFF);
        chk_outputs("R7 write ignored");
        pll_clk_ok = 1'b0;
        rd_chk("R7 pll low", 8'hFF);

        // R9: write every unmapped address, then read the whole map
        for (int a = 0; a < 256; a++) begin
            int op;
            if (map_idx(8'(a), op) < 0 && a != 255) wr(8'(a), 8'hFF);
        end
        chk_outputs("R9 unmapped write");
        for (int a = 0; a < 256; a++) rd_chk("R9 map sweep", 8'(a));

        // R10: read during same-cycle write returns old value; hold when idle
        wr(8'h0A, 8'h3C);
        @(negedge clk);
        addr = 8'h0A; wr_data = 8'hC3; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10 read before write", rd_data, 8'h3C);
        model_wr(8'h0A, 8'hC3);
        held = rd_data;
        wr(8'h0A, 8'h99);
        addr = 8'hFF;
        repeat (3) @(negedge clk);
        check("R10 hold", rd_data, held);
        rd_chk("R10 new value", 8'h0A);

        // R1: reset mid-run restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int k = 0; k < 8; k++) m[k] = (k == 6) ? 8'h01 : 8'h00;
        check("R1 rd_data after reset", rd_data, 8'h00);
        chk_outputs("R1 after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule